// File: doc/BRIEF.md
# Bit-Addressed Asynchronous Serial Port

This block is a full-duplex asynchronous serial port for a processor whose I/O bus carries one addressed bit per transfer. The processor builds an outgoing character by writing its eight bits, one per bus cycle, to bit addresses 0 to 7 in ascending order. The write to address 7 completes the character and starts the frame: a low start bit, eight data bits least significant first, and a high stop bit. The line rests high between frames. Every bit lasts sixteen ticks of a divider whose ratio `CLKS_PER_TICK` is a parameter.

The receiver checks for a start edge on each tick and confirms it at mid-bit. It samples each data bit and the stop bit once per bit time. A frame with a good stop bit places its byte on read addresses 0 to 7 and raises the read request. If a character completes while the read request is still set, the block flags a timing error. Status bits at addresses 8 to 15 report transmit-in-progress, timing error, write request, read request, the two synchronised modem lines, and a summary interrupt. A write of either value to a request address clears that request and touches nothing else.

The transmitter uses the states TX_IDLE, TX_START, TX_DATA and TX_STOP. It moves from TX_IDLE to TX_START on the start trigger, from TX_START to TX_DATA at the end of the start bit, and from TX_DATA to TX_STOP after the eighth data bit. It returns from TX_STOP to TX_IDLE at the end of the stop bit, which also raises the write request. The receiver uses the states RX_IDLE, RX_START, RX_DATA, RX_STOP and RX_BREAK. It moves from RX_IDLE to RX_START on a low line at a tick. At mid start bit it goes from RX_START back to RX_IDLE if the line is high, or on to RX_DATA if the line is still low. It moves from RX_DATA to RX_STOP after eight samples. At the stop sample it goes from RX_STOP to RX_IDLE if the line is high, which delivers the byte, or to RX_BREAK if the line is low. It leaves RX_BREAK for RX_IDLE once the line returns high.

Top module: `bitbus_serial_port`

## Requirements
- R1: A write to address n (0 to 7) stores `cpu_wdata` as bit n of the outgoing character. Writes to addresses 0 to 6 alone never start a frame.
- R2: A write to address 7 while no frame is in progress starts a frame on `txd`. The frame is a low start bit, then the eight held bits least significant first, then a high stop bit. Each bit lasts 16*CLKS_PER_TICK clocks, and `txd` is high when no frame is in progress.
- R3: Read address 8 (transmit in progress) is 1 from the cycle after the trigger until the end of the stop bit, about 160 ticks. It falls on the same clock edge that sets read address 11 (write request).
- R4: A received frame with a high stop bit makes its byte readable on addresses 0 to 7 (address n gives bit n) and sets read address 12 (read request).
- R5: If a frame completes while the read request is still set, read address 9 (timing error) sets and the new byte replaces the old one.
- R6: A write of either value to address 12 clears both the read request and the timing error.
- R7: A write of either value to address 11 clears the write request.
- R8: Writes to addresses 11 and 12 leave the held outgoing character, `txd` and the received byte unchanged.
- R9: Read address 15 and the `irq` port are 1 exactly when the write request or the read request is set.
- R10: Read addresses 13 and 14 return `dcd_in` and `dsr_in` after a two-flop synchroniser. Read address 10 always returns 0.
- R11: A low pulse on `rxd` shorter than half a bit is not taken as a start bit. A frame whose stop bit is low is discarded, and the receiver waits for the line to go high before looking for a new start.
- R12: A write to address 7 during a frame does not restart or extend it. Transmit in progress stays 1, and exactly one frame goes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 4 | Bit address of the current bus transfer |
| cpu_wr | input | 1 | Write strobe for the addressed bit |
| cpu_wdata | input | 1 | Bit value being written |
| cpu_rdata | output | 1 | Value of the addressed status or data bit |
| rxd | input | 1 | Serial receive line |
| dcd_in | input | 1 | Carrier detect from the modem |
| dsr_in | input | 1 | Data set ready from the modem |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Module interrupt request |

## Verification
A driver pushes each character it writes into a queue, and a monitor decodes every frame seen on `txd` and pops the queue to compare. A port that started on an early data bit, used the wrong bit order, or sent a second frame when address 7 was rewritten mid-frame would fail that comparison or leave an unexpected frame. The bench writes clear commands between data writes to show they leave the held character intact. It lets two characters arrive without a read to provoke the timing error. It sends a short glitch and a frame with a low stop bit, either of which would raise a false read request in a receiver without mid-bit confirmation or break handling. It measures the length of the transmit-in-progress interval, which a wrong divider or an extra state would stretch.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_t;

    localparam int ADDR_W = 4;
    localparam int CHAR_W = 8;

    localparam logic [ADDR_W-1:0] A_LAST_DATA = 4'd7;
    localparam logic [ADDR_W-1:0] A_WREQ      = 4'd11;
    localparam logic [ADDR_W-1:0] A_RREQ      = 4'd12;

endpackage

// File: rtl/bsp_sync.sv
module bsp_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/bsp_baud_gen.sv
module bsp_baud_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/bsp_tx.sv
module bsp_tx
    import bsp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);
    localparam logic [IW-1:0] LAST_BIT  = IW'(DATA_W - 1);

    tx_state_t         state_q, state_n;
    logic [CW-1:0]     tcnt_q;
    logic [IW-1:0]     bidx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              bit_end;

    assign bit_end = tick && (tcnt_q == LAST_TICK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            TX_IDLE:  if (start)   state_n = TX_START;
            TX_START: if (bit_end) state_n = TX_DATA;
            TX_DATA:  if (bit_end && bidx_q == LAST_BIT) state_n = TX_STOP;
            TX_STOP:  if (bit_end) state_n = TX_IDLE;
            default:  state_n = TX_IDLE;
        endcase
    end

    // bit timing and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q  <= '0;
            bidx_q  <= '0;
            shreg_q <= '0;
        end else begin
            if (state_q != state_n || state_q == TX_IDLE) begin
                tcnt_q <= '0;
            end else if (tick) begin
                tcnt_q <= (tcnt_q == LAST_TICK) ? '0 : tcnt_q + 1'b1;
            end
            if (state_q == TX_IDLE) begin
                bidx_q <= '0;
                if (start) shreg_q <= data;
            end else if (state_q == TX_DATA && bit_end) begin
                bidx_q  <= bidx_q + 1'b1;
                shreg_q <= shreg_q >> 1;
            end
        end
    end

    // outputs
    always_comb begin
        txd  = 1'b1;
        busy = (state_q != TX_IDLE);
        done = (state_q == TX_STOP) && bit_end;
        unique case (state_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg_q[0];
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd); // R2

endmodule

// File: rtl/bsp_rx.sv
module bsp_rx
    import bsp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] data
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);
    localparam logic [CW-1:0] MID_TICK  = CW'(OSR / 2 - 1);
    localparam logic [IW-1:0] LAST_BIT  = IW'(DATA_W - 1);

    rx_state_t         state_q, state_n;
    logic [CW-1:0]     tcnt_q;
    logic [IW-1:0]     bidx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              bit_end;

    assign bit_end = tick && (tcnt_q == LAST_TICK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RX_IDLE:  if (tick && !rxd) state_n = RX_START;
            RX_START: if (tick && tcnt_q == MID_TICK)
                          state_n = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && bidx_q == LAST_BIT) state_n = RX_STOP;
            RX_STOP:  if (bit_end) state_n = rxd ? RX_IDLE : RX_BREAK;
            RX_BREAK: if (rxd) state_n = RX_IDLE;
            default:  state_n = RX_IDLE;
        endcase
    end

    // sampling counters and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q  <= '0;
            bidx_q  <= '0;
            shreg_q <= '0;
        end else begin
            if (state_q != state_n) begin
                tcnt_q <= '0;
            end else if (tick) begin
                tcnt_q <= (tcnt_q == LAST_TICK) ? '0 : tcnt_q + 1'b1;
            end
            if (state_q != RX_DATA) begin
                bidx_q <= '0;
            end else if (bit_end) begin
                bidx_q  <= bidx_q + 1'b1;
                shreg_q <= {rxd, shreg_q[DATA_W-1:1]};
            end
        end
    end

    // outputs
    always_comb begin
        done = (state_q == RX_STOP) && bit_end && rxd;
        data = shreg_q;
    end

    AST_RX_CONFIRM_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && state_n == RX_DATA) |-> !rxd); // R11

endmodule

// File: rtl/bitbus_serial_port.sv
module bitbus_serial_port
    import bsp_pkg::*;
#(
    parameter int CLKS_PER_TICK = 8,
    parameter int OVERSAMPLE    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_wdata,
    output logic              cpu_rdata,
    input  logic              rxd,
    input  logic              dcd_in,
    input  logic              dsr_in,
    output logic              txd,
    output logic              irq
);
    localparam int STAT_W = 1 << ADDR_W;

    logic              tick;
    logic [2:0]        sync_q;
    logic              rxd_s, dcd_s, dsr_s;
    logic [CHAR_W-1:0] hold_q;
    logic [CHAR_W-1:0] rxbuf_q;
    logic [CHAR_W-1:0] rx_data;
    logic              wreq_q, rreq_q, timerr_q;
    logic              wr_data_bit, clr_wreq, clr_rreq, tx_start;
    logic              tx_busy, tx_done, rx_done;
    logic [STAT_W-1:0] stat;

    bsp_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dsr_in, dcd_in, rxd}),
        .q     (sync_q)
    );
    assign rxd_s = sync_q[0];
    assign dcd_s = sync_q[1];
    assign dsr_s = sync_q[2];

    bsp_baud_gen #(.DIV(CLKS_PER_TICK)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // bus decode
    assign wr_data_bit = cpu_wr && !cpu_addr[ADDR_W-1];
    assign clr_wreq    = cpu_wr && (cpu_addr == A_WREQ);
    assign clr_rreq    = cpu_wr && (cpu_addr == A_RREQ);
    assign tx_start    = cpu_wr && (cpu_addr == A_LAST_DATA) && !tx_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_data_bit) begin
            hold_q[cpu_addr[2:0]] <= cpu_wdata;
        end
    end

    bsp_tx #(.DATA_W(CHAR_W), .OSR(OVERSAMPLE)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .start (tx_start),
        .data  ({cpu_wdata, hold_q[CHAR_W-2:0]}),
        .txd   (txd),
        .busy  (tx_busy),
        .done  (tx_done)
    );

    bsp_rx #(.DATA_W(CHAR_W), .OSR(OVERSAMPLE)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .rxd   (rxd_s),
        .done  (rx_done),
        .data  (rx_data)
    );

    // request and error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wreq_q   <= 1'b0;
            rreq_q   <= 1'b0;
            timerr_q <= 1'b0;
            rxbuf_q  <= '0;
        end else begin
            if (tx_done)       wreq_q <= 1'b1;
            else if (clr_wreq) wreq_q <= 1'b0;

            if (rx_done) begin
                rxbuf_q  <= rx_data;
                rreq_q   <= 1'b1;
                timerr_q <= (rreq_q && !clr_rreq) || (timerr_q && !clr_rreq);
            end else if (clr_rreq) begin
                rreq_q   <= 1'b0;
                timerr_q <= 1'b0;
            end
        end
    end

    assign irq = wreq_q | rreq_q;

    always_comb begin
        stat              = '0;
        stat[CHAR_W-1:0]  = rxbuf_q;
        stat[8]           = tx_busy;
        stat[9]           = timerr_q;
        stat[11]          = wreq_q;
        stat[12]          = rreq_q;
        stat[13]          = dcd_s;
        stat[14]          = dsr_s;
        stat[15]          = irq;
    end

    assign cpu_rdata = stat[cpu_addr];

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> tx_busy); // R2
    AST_TIP_END_WREQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> wreq_q); // R3
    AST_RX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rreq_q); // R4
    AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rreq_q && !clr_rreq) |=> timerr_q); // R5
    AST_RREQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rreq && !rx_done) |=> (!rreq_q && !timerr_q)); // R6
    AST_WREQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wreq && !tx_done) |=> !wreq_q); // R7
    AST_CLEAR_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wreq || clr_rreq) |=> $stable(hold_q)); // R8
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd); // R2

endmodule

// File: tb/tb_bitbus_serial_port.sv
module tb_bitbus_serial_port;
    localparam int DIV    = 4;
    localparam int TCLK   = 8;
    localparam int BIT_NS = 16 * DIV * TCLK;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0;
    logic       cpu_wdata = 1'b0;
    logic       cpu_rdata;
    logic       rxd = 1'b1;
    logic       dcd_in = 1'b0;
    logic       dsr_in = 1'b0;
    logic       txd;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    int frames_seen = 0;
    byte unsigned exp_q[$];

    always #4 clk = ~clk;

    bitbus_serial_port #(.CLKS_PER_TICK(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rxd(rxd),
        .dcd_in(dcd_in), .dsr_in(dsr_in), .txd(txd), .irq(irq)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(int addr, bit val);
        @(negedge clk);
        cpu_addr  = 4'(addr);
        cpu_wdata = val;
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    task automatic cpu_read(int addr, output bit v);
        @(negedge clk);
        cpu_addr = 4'(addr);
        #1;
        v = cpu_rdata;
    endtask

    task automatic read_byte(output byte unsigned b);
        bit v;
        b = 0;
        for (int i = 0; i < 8; i++) begin
            cpu_read(i, v);
            b[i] = v;
        end
    endtask

    // driver: record expectation, then write bits 0..7
    task automatic send_char(byte unsigned c);
        exp_q.push_back(c);
        for (int i = 0; i < 8; i++) cpu_write(i, c[i]);
    endtask

    task automatic wait_tx_idle(output int cycles);
        bit v;
        cycles = 0;
        do begin
            cpu_read(8, v);
            cycles++;
        end while (v && cycles < 4000);
    endtask

    task automatic drive_rx(byte unsigned d, bit stop_ok);
        rxd = 1'b0;
        #(BIT_NS);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            #(BIT_NS);
        end
        rxd = stop_ok;
        #(BIT_NS);
        if (!stop_ok) #(BIT_NS);
        rxd = 1'b1;
        #(BIT_NS);
    endtask

    // monitor: decode frames on txd and compare against the queue (R2)
    initial begin
        byte unsigned got;
        forever begin
            @(negedge txd);
            #(BIT_NS / 2 + 3);
            check("R2", "start bit level", int'(txd), 0);
            for (int i = 0; i < 8; i++) begin
                #(BIT_NS);
                got[i] = txd;
            end
            #(BIT_NS);
            check("R2", "stop bit level", int'(txd), 1);
            frames_seen++;
            if (exp_q.size() == 0) begin
                check("R12", "unexpected extra frame", int'(got), -1);
            end else begin
                check("R2", "frame data", int'(got), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(TCLK * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit v;
        int cyc;
        byte unsigned b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R2", "txd idle after reset", int'(txd), 1);
        check("R9", "irq after reset", int'(irq), 0);
        cpu_read(8, v);  check("R3", "tip after reset", int'(v), 0);
        cpu_read(11, v); check("R7", "wreq after reset", int'(v), 0);
        cpu_read(12, v); check("R4", "rreq after reset", int'(v), 0);

        // R1: partial character does not start a frame
        for (int i = 0; i < 7; i++) cpu_write(i, 8'hA5 >> i);
        #(2 * BIT_NS);
        cpu_read(8, v);
        check("R1", "tip after bits 0..6", int'(v), 0);
        check("R1", "txd after bits 0..6", int'(txd), 1);
        check("R1", "frames after bits 0..6", frames_seen, 0);

        // R2/R3: bit 7 completes and starts the frame
        exp_q.push_back(8'hA5);
        cpu_write(7, 1'b1);
        wait_tx_idle(cyc);
        check("R3", "tip length in range", int'(cyc >= 159 * DIV && cyc <= 160 * DIV + 1), 1);
        cpu_read(11, v); check("R3", "wreq set as tip falls", int'(v), 1);
        cpu_read(15, v); check("R9", "addr 15 with wreq", int'(v), 1);
        check("R9", "irq with wreq", int'(irq), 1);
        cpu_write(11, 1'b0);
        cpu_read(11, v); check("R7", "wreq cleared by 0 write", int'(v), 0);
        check("R9", "irq after clear", int'(irq), 0);

        // R8: clear writes interleaved with data writes
        #(BIT_NS);
        for (int i = 0; i < 4; i++) cpu_write(i, 8'h3C >> i);
        cpu_write(12, 1'b1);
        cpu_write(11, 1'b1);
        check("R8", "txd untouched by clears", int'(txd), 1);
        cpu_read(8, v); check("R8", "no frame from clears", int'(v), 0);
        exp_q.push_back(8'h3C);
        for (int i = 4; i < 8; i++) cpu_write(i, 8'h3C >> i);
        wait_tx_idle(cyc);
        cpu_write(11, 1'b1);

        // R12: retrigger during a frame
        #(BIT_NS);
        send_char(8'h81);
        #(3 * BIT_NS);
        cpu_write(7, 1'b1);
        cpu_read(8, v); check("R12", "tip after mid-frame trigger", int'(v), 1);
        wait_tx_idle(cyc);
        cpu_write(11, 1'b1);
        #(3 * BIT_NS);
        check("R12", "single frame sent", frames_seen, 3);

        // R4: receive
        drive_rx(8'h5A, 1'b1);
        cpu_read(12, v); check("R4", "rreq after frame", int'(v), 1);
        read_byte(b);    check("R4", "received byte", int'(b), 8'h5A);
        cpu_read(9, v);  check("R5", "no timing error yet", int'(v), 0);
        check("R9", "irq with rreq", int'(irq), 1);

        // R5: overrun
        drive_rx(8'hC3, 1'b1);
        cpu_read(9, v);  check("R5", "timing error on overrun", int'(v), 1);
        read_byte(b);    check("R5", "new byte replaces old", int'(b), 8'hC3);

        // R6: clear with value 0
        cpu_write(12, 1'b0);
        cpu_read(12, v); check("R6", "rreq cleared", int'(v), 0);
        cpu_read(9, v);  check("R6", "timing error cleared", int'(v), 0);
        read_byte(b);    check("R8", "rx byte kept across clear", int'(b), 8'hC3);
        check("R9", "irq idle", int'(irq), 0);

        // R11: glitch and bad stop bit
        rxd = 1'b0;
        #(4 * DIV * TCLK);
        rxd = 1'b1;
        #(12 * BIT_NS);
        cpu_read(12, v); check("R11", "glitch rejected", int'(v), 0);
        drive_rx(8'h77, 1'b0);
        #(2 * BIT_NS);
        cpu_read(12, v); check("R11", "bad stop discarded", int'(v), 0);
        drive_rx(8'h12, 1'b1);
        read_byte(b);    check("R11", "receiver recovers after break", int'(b), 8'h12);
        cpu_write(12, 1'b1);

        // R10: modem lines and constant bit
        dcd_in = 1'b1;
        repeat (3) @(negedge clk);
        cpu_read(13, v); check("R10", "dcd visible", int'(v), 1);
        cpu_read(14, v); check("R10", "dsr low", int'(v), 0);
        dsr_in = 1'b1;
        repeat (3) @(negedge clk);
        cpu_read(14, v); check("R10", "dsr visible", int'(v), 1);
        cpu_read(10, v); check("R10", "addr 10 reads 0", int'(v), 0);

        #(2 * BIT_NS);
        check("R2", "queue drained", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule